// File: doc/BRIEF.md
# DMA stream control register

This block holds the configuration and run control for one DMA stream. Software reaches it through a simple word-wide write port, and its whole state can be read back at all times. The register holds these settings: a request channel number, the burst lengths on the memory and peripheral sides, the data sizes, the address increment controls, the transfer direction, the priority, the circular and double-buffer options, four interrupt enables and the stream enable bit. The data mover, the FIFO, the address registers and the interrupt logic sit outside this block. They reach it only through a few strobes and a few decoded outputs.

While the stream runs, software writes can change only the enable bit. This lets software stop a stream without disturbing its setup. A hardware stop strobe clears the enable, and it wins over a software write that sets the enable in the same cycle. When the direct-mode input is high, the peripheral burst is held at single transfers. The memory burst is also held at single transfers as soon as the stream is enabled. The current-target bit chooses the first buffer while the stream is idle. Once the stream runs, the bit toggles at each buffer-completion strobe when double buffering is on.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After a synchronous reset, rd_data is 0x00000000, stream_on is 0, chan_id is 0 and both beat outputs are 1.
- R2: Bits 31:28 and bit 20 of rd_data always read as 0. Writing 1s to those positions has no effect.
- R3: While the enable bit is 0, a write loads every field, and rd_data shows it on the next cycle at these positions: channel 27:25, memory burst 24:23, peripheral burst 22:21, current target 19, double buffer 18, priority 17:16, peripheral offset select 15, memory size 14:13, peripheral size 12:11, memory increment 10, peripheral increment 9, circular 8, direction 7:6, flow control 5, interrupt enables 4:1, enable 0.
- R4: While the enable bit is 1, a write updates only bit 0. All other bits keep their values, including the current target and the interrupt enables.
- R5: A stream_stop pulse clears the enable bit on the next edge. This holds even when the same cycle carries a write that sets bit 0. The other fields of that write still load if the stream was idle.
- R6: In any cycle where direct_mode is 1, the peripheral burst field becomes 00 at the next edge. This holds even while the stream is enabled.
- R7: If direct_mode is 1 and the enable bit is 1 after the edge, the memory burst field is 00. When direct_mode is 0, the memory burst keeps the value that was written.
- R8: While the enable bit is 1 and double buffer (bit 18) is 1, each buffer_done pulse inverts the current target (bit 19). The pulse has no effect when double buffer is 0 or when the stream is idle.
- R9: mem_beats and per_beats give the burst length for the stored code: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16.
- R10: chan_id equals the stored channel field. chan_onehot has exactly bit chan_id set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data word |
| direct_mode | input | 1 | High when the stream runs without FIFO buffering |
| buffer_done | input | 1 | Pulse when the current buffer has completed |
| stream_stop | input | 1 | Pulse from hardware that ends the stream (done or error) |
| rd_data | output | 32 | Register read-back word |
| stream_on | output | 1 | Enable bit |
| current_target | output | 1 | Current target buffer (0 or 1) |
| chan_id | output | 3 | Selected request channel |
| chan_onehot | output | 8 | One-hot form of the selected channel |
| mem_beats | output | 5 | Memory-side burst length in beats |
| per_beats | output | 5 | Peripheral-side burst length in beats |

## Verification
The properties assume that buffer_done and stream_stop are single-cycle pulses. They also assume that direct_mode changes only between writes. The check on locked fields further assumes that direct_mode is low, because forcing is the only legal change to a locked field. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It raises direct_mode only in the cases written to exercise forcing, and it lowers it again before the locking sweeps.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int REG_W   = 32;
    localparam int CHSEL_W = 3;
    localparam int BURST_W = 2;

    typedef enum logic [BURST_W-1:0] {
        BURST_SINGLE = 2'b00,
        BURST_INC4   = 2'b01,
        BURST_INC8   = 2'b10,
        BURST_INC16  = 2'b11
    } burst_e;

    typedef struct packed {
        logic [3:0]         rsv_hi;
        logic [CHSEL_W-1:0] chan_sel;
        burst_e             mem_burst;
        burst_e             per_burst;
        logic               rsv_mid;
        logic               cur_tgt;
        logic               dbl_buf;
        logic [1:0]         prio;
        logic               per_ofs_fixed;
        logic [1:0]         mem_size;
        logic [1:0]         per_size;
        logic               mem_inc;
        logic               per_inc;
        logic               circ;
        logic [1:0]         xfer_dir;
        logic               per_flow;
        logic               ie_done;
        logic               ie_half;
        logic               ie_err;
        logic               ie_dm;
        logic               enable;
    } cfg_t;

    // Reserved positions are zeroed before anything is stored.
    function automatic cfg_t scrub(input logic [REG_W-1:0] word);
        cfg_t c;
        c = cfg_t'(word);
        c.rsv_hi  = '0;
        c.rsv_mid = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/dsc_write_filter.sv
module dsc_write_filter
    import dsc_pkg::*;
(
    input  cfg_t             cur,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             direct_mode,
    input  logic             stream_stop,
    output cfg_t             nxt,
    output logic             tgt_load,
    output logic             tgt_value
);

    cfg_t incoming;

    always_comb begin
        incoming  = scrub(wr_data);
        nxt       = cur;
        tgt_load  = 1'b0;
        tgt_value = incoming.cur_tgt;

        if (wr_en) begin
            if (!cur.enable) begin
                nxt      = incoming;
                tgt_load = 1'b1;
            end else begin
                // Locked stream: only the run bit is open to software.
                nxt.enable = incoming.enable;
            end
        end

        // A hardware stop outranks a software enable.
        if (stream_stop) begin
            nxt.enable = 1'b0;
        end

        if (direct_mode) begin
            nxt.per_burst = BURST_SINGLE;
            if (nxt.enable) begin
                nxt.mem_burst = BURST_SINGLE;
            end
        end
    end

endmodule

// File: rtl/dsc_target_tracker.sv
module dsc_target_tracker (
    input  logic running,
    input  logic dbl_buf,
    input  logic buffer_done,
    input  logic sw_load,
    input  logic sw_value,
    input  logic cur_tgt,
    output logic nxt_tgt
);

    always_comb begin
        if (sw_load) begin
            nxt_tgt = sw_value;
        end else if (running && dbl_buf && buffer_done) begin
            nxt_tgt = ~cur_tgt;
        end else begin
            nxt_tgt = cur_tgt;
        end
    end

endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
    import dsc_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int BEAT_W   = 5,
    localparam int CHAN_W  = $clog2(NUM_CHAN)
) (
    input  logic [CHAN_W-1:0]   chan_sel,
    input  burst_e              mem_burst,
    input  burst_e              per_burst,
    output logic [CHAN_W-1:0]   chan_id,
    output logic [NUM_CHAN-1:0] chan_onehot,
    output logic [BEAT_W-1:0]   mem_beats,
    output logic [BEAT_W-1:0]   per_beats
);

    function automatic logic [BEAT_W-1:0] beats_of(input burst_e code);
        if (code == BURST_SINGLE) begin
            return BEAT_W'(1);
        end
        return BEAT_W'(2) << code;
    endfunction

    assign chan_id   = chan_sel;
    assign mem_beats = beats_of(mem_burst);
    assign per_beats = beats_of(per_burst);

    for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_chan
        assign chan_onehot[gi] = (chan_sel == CHAN_W'(gi));
    end

endmodule

// File: rtl/dma_stream_ctrl.sv
module dma_stream_ctrl
    import dsc_pkg::*;
#(
    parameter int NUM_CHAN  = 8,
    parameter int MAX_BEATS = 16,
    localparam int CHAN_W   = $clog2(NUM_CHAN),
    localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                direct_mode,
    input  logic                buffer_done,
    input  logic                stream_stop,
    output logic [REG_W-1:0]    rd_data,
    output logic                stream_on,
    output logic                current_target,
    output logic [CHAN_W-1:0]   chan_id,
    output logic [NUM_CHAN-1:0] chan_onehot,
    output logic [BEAT_W-1:0]   mem_beats,
    output logic [BEAT_W-1:0]   per_beats
);

    cfg_t cfg_q;
    cfg_t filt_nxt;
    cfg_t cfg_d;
    logic tgt_load;
    logic tgt_value;
    logic tgt_nxt;

    dsc_write_filter u_filter (
        .cur         (cfg_q),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .direct_mode (direct_mode),
        .stream_stop (stream_stop),
        .nxt         (filt_nxt),
        .tgt_load    (tgt_load),
        .tgt_value   (tgt_value)
    );

    dsc_target_tracker u_target (
        .running     (cfg_q.enable),
        .dbl_buf     (cfg_q.dbl_buf),
        .buffer_done (buffer_done),
        .sw_load     (tgt_load),
        .sw_value    (tgt_value),
        .cur_tgt     (cfg_q.cur_tgt),
        .nxt_tgt     (tgt_nxt)
    );

    always_comb begin
        cfg_d         = filt_nxt;
        cfg_d.cur_tgt = tgt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    dsc_decode #(
        .NUM_CHAN (NUM_CHAN),
        .BEAT_W   (BEAT_W)
    ) u_decode (
        .chan_sel    (cfg_q.chan_sel),
        .mem_burst   (cfg_q.mem_burst),
        .per_burst   (cfg_q.per_burst),
        .chan_id     (chan_id),
        .chan_onehot (chan_onehot),
        .mem_beats   (mem_beats),
        .per_beats   (per_beats)
    );

    assign rd_data        = cfg_q;
    assign stream_on      = cfg_q.enable;
    assign current_target = cfg_q.cur_tgt;

endmodule

// File: rtl/dma_stream_ctrl_chk.sv
module dma_stream_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        direct_mode,
    input logic        buffer_done,
    input logic        stream_stop,
    input logic [31:0] rd_data,
    input logic        stream_on
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_data[31:28] == 4'h0) && (rd_data[20] == 1'b0));

    // R4
    locked_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (stream_on && !direct_mode) |=>
            (rd_data[31:20] == $past(rd_data[31:20])) &&
            (rd_data[18:1] == $past(rd_data[18:1])));

    // R5
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        stream_stop |=> !stream_on);

    // R6
    per_single_chk: assert property (@(posedge clk) disable iff (rst)
        direct_mode |=> (rd_data[22:21] == 2'b00));

    // R7
    mem_single_chk: assert property (@(posedge clk) disable iff (rst)
        direct_mode |=> (!rd_data[0] || (rd_data[24:23] == 2'b00)));

    // R8
    target_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (stream_on && rd_data[18] && buffer_done) |=>
            (rd_data[19] != $past(rd_data[19])));

endmodule

bind dma_stream_ctrl dma_stream_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .direct_mode (direct_mode),
    .buffer_done (buffer_done),
    .stream_stop (stream_stop),
    .rd_data     (rd_data),
    .stream_on   (stream_on)
);

// File: tb/dma_stream_ctrl_test.sv
`timescale 1ns/1ps
module dma_stream_ctrl_test;

    localparam logic [31:0] RSV = 32'hF010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        direct_mode = 1'b0;
    logic        buffer_done = 1'b0;
    logic        stream_stop = 1'b0;
    logic [31:0] rd_data;
    logic        stream_on;
    logic        current_target;
    logic [2:0]  chan_id;
    logic [7:0]  chan_onehot;
    logic [4:0]  mem_beats;
    logic [4:0]  per_beats;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_stream_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .direct_mode    (direct_mode),
        .buffer_done    (buffer_done),
        .stream_stop    (stream_stop),
        .rd_data        (rd_data),
        .stream_on      (stream_on),
        .current_target (current_target),
        .chan_id        (chan_id),
        .chan_onehot    (chan_onehot),
        .mem_beats      (mem_beats),
        .per_beats      (per_beats)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge; the result is visible at the following falling edge.
    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        buffer_done = 1'b1;
        @(negedge clk);
        buffer_done = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stream_stop = 1'b1;
        @(negedge clk);
        stream_stop = 1'b0;
    endtask

    function automatic logic [4:0] beats(input logic [1:0] code);
        return (code == 2'b00) ? 5'd1 : (5'd2 << code);
    endfunction

    initial begin
        logic [31:0] base;
        logic        tgt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 stream_on", {31'b0, stream_on}, 32'h0);
        check("R1 chan_id", {29'b0, chan_id}, 32'h0);
        check("R1 mem_beats", {27'b0, mem_beats}, 32'd1);
        check("R1 per_beats", {27'b0, per_beats}, 32'd1);

        // R3 / R2 idle writes of varied patterns, reserved bits set on purpose
        for (int i = 0; i < 64; i++) begin
            automatic logic [31:0] p = (32'h9E37_79B1 * i) ^ (i << 9) ^ RSV;
            p[0] = 1'b0;
            write_word(p);
            check("R3 idle load", rd_data, p & ~RSV);
            check("R2 reserved", rd_data & RSV, 32'h0);
        end

        // R10 channel sweep, field 27:25
        for (int c = 0; c < 8; c++) begin
            write_word(32'(c) << 25);
            check("R10 chan_id", {29'b0, chan_id}, 32'(c));
            check("R10 onehot", {24'b0, chan_onehot}, 32'(1) << c);
        end

        // R9 burst sweep, memory 24:23 and peripheral 22:21
        for (int m = 0; m < 4; m++) begin
            for (int q = 0; q < 4; q++) begin
                write_word((32'(m) << 23) | (32'(q) << 21));
                check("R9 mem_beats", {27'b0, mem_beats}, {27'b0, beats(2'(m))});
                check("R9 per_beats", {27'b0, per_beats}, {27'b0, beats(2'(q))});
            end
        end

        // R4 locking while enabled
        base = 32'h0B5A_A5FE;
        write_word(base | 32'h1);
        check("R4 enable loads", rd_data, (base | 32'h1) & ~RSV);
        for (int i = 0; i < 16; i++) begin
            automatic logic [31:0] p = (32'hC2B2_AE35 * (i + 1)) | 32'h1;
            write_word(p);
            check("R4 locked", rd_data, (base | 32'h1) & ~RSV);
        end
        write_word(32'hFFFF_FFFE);
        check("R4 disable only", rd_data, base & ~RSV);

        // R5 hardware stop
        write_word(32'h0000_0001);
        check("R5 running", {31'b0, stream_on}, 32'h1);
        pulse_stop();
        check("R5 stop clears", {31'b0, stream_on}, 32'h0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h0C03_0F11;
        stream_stop = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        stream_stop = 1'b0;
        check("R5 stop beats write", rd_data, 32'h0C03_0F10);

        // R6 / R7 direct mode
        direct_mode = 1'b1;
        write_word(32'h01E0_0000);
        check("R6 per forced idle", rd_data[24:21], 32'h0000_000C);
        write_word(32'h01E0_0001);
        check("R7 mem forced on enable", rd_data[24:21], 32'h0);
        direct_mode = 1'b0;
        write_word(32'h0000_0000);
        write_word(32'h0140_0001);
        check("R7 no force outside direct", rd_data[24:21], 32'h0000_000A);
        @(negedge clk);
        direct_mode = 1'b1;
        @(negedge clk);
        direct_mode = 1'b0;
        check("R6 per forced while on", rd_data[22:21], 32'h0);
        check("R7 mem forced while on", rd_data[24:23], 32'h0);
        write_word(32'h0000_0000);

        // R8 current target, bit 19, double buffer bit 18
        write_word(32'h000C_0000);
        check("R8 sw target idle", {31'b0, current_target}, 32'h1);
        pulse_done();
        check("R8 no flip idle", {31'b0, current_target}, 32'h1);
        write_word(32'h000C_0001);
        tgt = 1'b1;
        for (int i = 0; i < 5; i++) begin
            pulse_done();
            tgt = ~tgt;
            check("R8 flip", {31'b0, current_target}, {31'b0, tgt});
        end
        write_word(32'h0);
        write_word(32'h0000_0001);
        pulse_done();
        check("R8 no flip single buffer", {31'b0, current_target}, 32'h0);
        write_word(32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule